// File: doc/BRIEF.md
# Data-Available and Field Flag Generator

This block drives two status pins of a broadcast data decoder. The first pin is active low and tells a host controller that a fresh block of received data has been stored and can be read. The second pin tells which field of the interlaced frame is in progress. Video timing extraction and data validation happen elsewhere. They reach this block as single-cycle strobes: the start of line 16, the start of the data entry window, the start of the first field and of the second field, a "valid data stored" pulse from acquisition, and a pulse when the bus master ends a read with a not-acknowledge ahead of a STOP.

The point at which the data flag is released depends on the operating mode. In the dedicated-line mode the flag is released when line 16 starts again. In the packet and header modes it is released when the next data entry window opens. A master not-acknowledge releases it in every mode. A store and a release in the same cycle leave the flag set.

For board test, a test input makes both pins copy a strap input. The internal state keeps tracking events while this is happening. Both pins come from flip-flops, so they cannot glitch.

Top module: `avail_flag_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the data pin `data_avail_n_o` is 1 and the field pin `field_one_o` is 0.
- R2: A `store_valid_i` pulse drives `data_avail_n_o` to 0 on the next rising clock edge, in every mode.
- R3: With `mode_i` = 0 (dedicated-line mode), a `line16_start_i` pulse returns `data_avail_n_o` to 1 on the next edge, and a `window_start_i` pulse has no effect on it.
- R4: With `mode_i` = 1 (packet mode), 2 (header mode) or 3 (treated as header mode), a `window_start_i` pulse returns `data_avail_n_o` to 1 on the next edge, and a `line16_start_i` pulse has no effect on it.
- R5: A `master_nack_i` pulse returns `data_avail_n_o` to 1 on the next edge, in every mode.
- R6: When `store_valid_i` and any release event are present in the same cycle, the store wins and `data_avail_n_o` is 0 after the edge.
- R7: A `first_field_i` pulse sets `field_one_o` to 1 on the next edge. A `second_field_i` pulse clears it to 0 on the next edge. Without either pulse the pin holds its value.
- R8: While `test_en_i` is 1, both `data_avail_n_o` and `field_one_o` take the level of `strap_i` on each rising edge.
- R9: Events that arrive while `test_en_i` is 1 still update the internal flags. One edge after `test_en_i` returns to 0, the pins show the tracked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | MODE_W | Operating mode: 0 dedicated line, 1 packet, 2/3 header |
| line16_start_i | input | 1 | Strobe at the start of line 16 |
| window_start_i | input | 1 | Strobe at the start of the data entry window |
| first_field_i | input | 1 | Strobe at the start of the first field |
| second_field_i | input | 1 | Strobe at the start of the second field |
| store_valid_i | input | 1 | Pulse when valid data has been stored |
| master_nack_i | input | 1 | Pulse when the master does not acknowledge before STOP |
| test_en_i | input | 1 | Test mode enable |
| strap_i | input | 1 | Strap level copied to both pins in test mode |
| data_avail_n_o | output | 1 | Data available, active low, registered |
| field_one_o | output | 1 | High during the first field, registered |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its strobe or level is presented. This applies to a store, a release, a field strobe and a test-mode strap change alike. The bench changes inputs just after a falling edge, holds them across one rising edge, and samples both pins at the following falling edge. Each check therefore lands on the first cycle in which the new value is due. The no-effect cases are sampled in the same cycle in which a wrong-mode release would have shown. The test-mode carry-over case is sampled on the single edge after test mode is left.

// File: rtl/avf_pkg.sv
package avf_pkg;

    // Registered state of the generator
    typedef struct packed {
        logic avail;      // data stored, not yet released
        logic field_one;  // first field in progress
        logic davn;       // pin register, active low
        logic ehb;        // pin register
    } avf_state_t;

    localparam avf_state_t AVF_RESET = '{avail: 1'b0, field_one: 1'b0,
                                         davn: 1'b1, ehb: 1'b0};

endpackage

// File: rtl/avf_avail_next.sv
module avf_avail_next #(
    parameter int MODE_W = 2
) (
    input  logic              avail_q,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              line16_i,
    input  logic              window_i,
    input  logic              store_i,
    input  logic              nack_i,
    output logic              avail_d
);
    localparam logic [MODE_W-1:0] LINE_MODE = '0;

    logic line_mode;
    logic release_evt;

    assign line_mode   = (mode_i == LINE_MODE);
    assign release_evt = nack_i | (line_mode ? line16_i : window_i);

    always_comb begin
        if (store_i) begin
            avail_d = 1'b1;           // set wins over any release
        end else if (release_evt) begin
            avail_d = 1'b0;
        end else begin
            avail_d = avail_q;
        end
    end
endmodule

// File: rtl/avf_field_next.sv
module avf_field_next (
    input  logic field_q,
    input  logic first_i,
    input  logic second_i,
    output logic field_d
);
    always_comb begin
        if (first_i) begin
            field_d = 1'b1;
        end else if (second_i) begin
            field_d = 1'b0;
        end else begin
            field_d = field_q;
        end
    end
endmodule

// File: rtl/avf_pin_mux.sv
module avf_pin_mux (
    input  logic test_i,
    input  logic strap_i,
    input  logic avail_d,
    input  logic field_d,
    output logic davn_d,
    output logic ehb_d
);
    always_comb begin
        if (test_i) begin
            davn_d = strap_i;
            ehb_d  = strap_i;
        end else begin
            davn_d = ~avail_d;
            ehb_d  = field_d;
        end
    end
endmodule

// File: rtl/avail_flag_gen.sv
module avail_flag_gen
    import avf_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              line16_start_i,
    input  logic              window_start_i,
    input  logic              first_field_i,
    input  logic              second_field_i,
    input  logic              store_valid_i,
    input  logic              master_nack_i,
    input  logic              test_en_i,
    input  logic              strap_i,
    output logic              data_avail_n_o,
    output logic              field_one_o
);
    avf_state_t st_d, st_q;
    logic avail_d, field_d, davn_d, ehb_d;

    avf_avail_next #(.MODE_W(MODE_W)) u_avail (
        .avail_q  (st_q.avail),
        .mode_i   (mode_i),
        .line16_i (line16_start_i),
        .window_i (window_start_i),
        .store_i  (store_valid_i),
        .nack_i   (master_nack_i),
        .avail_d  (avail_d)
    );

    avf_field_next u_field (
        .field_q  (st_q.field_one),
        .first_i  (first_field_i),
        .second_i (second_field_i),
        .field_d  (field_d)
    );

    avf_pin_mux u_mux (
        .test_i  (test_en_i),
        .strap_i (strap_i),
        .avail_d (avail_d),
        .field_d (field_d),
        .davn_d  (davn_d),
        .ehb_d   (ehb_d)
    );

    always_comb begin
        st_d           = st_q;
        st_d.avail     = avail_d;
        st_d.field_one = field_d;
        st_d.davn      = davn_d;
        st_d.ehb       = ehb_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= AVF_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_avail_n_o = st_q.davn;
    assign field_one_o    = st_q.ehb;
endmodule

// File: rtl/avf_checker.sv
module avf_checker #(
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              line16_start_i,
    input logic              window_start_i,
    input logic              first_field_i,
    input logic              second_field_i,
    input logic              store_valid_i,
    input logic              master_nack_i,
    input logic              test_en_i,
    input logic              strap_i,
    input logic              data_avail_n_o,
    input logic              field_one_o
);
    AST_RESET_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_avail_n_o && !field_one_o)); // R1

    AST_STORE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && store_valid_i) |=> !data_avail_n_o); // R2

    AST_LINE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && !store_valid_i && mode_i == '0 && line16_start_i)
        |=> data_avail_n_o); // R3

    AST_WINDOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && !store_valid_i && mode_i != '0 && window_start_i)
        |=> data_avail_n_o); // R4

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && !store_valid_i && master_nack_i) |=> data_avail_n_o); // R5

    AST_SET_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && store_valid_i &&
         (master_nack_i || line16_start_i || window_start_i))
        |=> !data_avail_n_o); // R6

    AST_FIELD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && first_field_i) |=> field_one_o); // R7

    AST_FIELD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en_i && !first_field_i && second_field_i) |=> !field_one_o); // R7

    AST_TEST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_i |=> (data_avail_n_o == $past(strap_i) &&
                       field_one_o == $past(strap_i))); // R8
endmodule

bind avail_flag_gen avf_checker #(.MODE_W(MODE_W)) u_avf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .line16_start_i (line16_start_i),
    .window_start_i (window_start_i),
    .first_field_i  (first_field_i),
    .second_field_i (second_field_i),
    .store_valid_i  (store_valid_i),
    .master_nack_i  (master_nack_i),
    .test_en_i      (test_en_i),
    .strap_i        (strap_i),
    .data_avail_n_o (data_avail_n_o),
    .field_one_o    (field_one_o)
);

// File: tb/avail_flag_gen_bench.sv
`timescale 1ns/1ps
module avail_flag_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       l16, win, ff1, ff2, stv, nak, tst, strap;
    logic       davn, ehb;
    int         checks = 0;
    int         fails  = 0;

    always #2.5 clk = ~clk;

    avail_flag_gen u_avail_flag_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode),
        .line16_start_i (l16),
        .window_start_i (win),
        .first_field_i  (ff1),
        .second_field_i (ff2),
        .store_valid_i  (stv),
        .master_nack_i  (nak),
        .test_en_i      (tst),
        .strap_i        (strap),
        .data_avail_n_o (davn),
        .field_one_o    (ehb)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b", what, got, exp);
        end
    endtask

    // Drive strobes for one cycle; returns at the falling edge after the rising edge.
    task automatic pulse(input logic p_l16, input logic p_win, input logic p_ff1,
                         input logic p_ff2, input logic p_stv, input logic p_nak);
        l16 = p_l16; win = p_win; ff1 = p_ff1; ff2 = p_ff2; stv = p_stv; nak = p_nak;
        @(negedge clk);
        l16 = 0; win = 0; ff1 = 0; ff2 = 0; stv = 0; nak = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; mode = 0; tst = 0; strap = 0;
        l16 = 0; win = 0; ff1 = 0; ff2 = 0; stv = 1; nak = 0;
        repeat (3) @(negedge clk);
        chk(davn, 1'b1, "R1 davn in reset");
        chk(ehb,  1'b0, "R1 ehb in reset");
        stv = 0;
        rst_n = 1;
        @(negedge clk);
        chk(davn, 1'b1, "R1 davn after reset");
        chk(ehb,  1'b0, "R1 ehb after reset");
    endtask

    task automatic t_line_mode();
        mode = 0;
        pulse(0, 0, 0, 0, 1, 0);
        chk(davn, 1'b0, "R2 store in line mode");
        pulse(0, 1, 0, 0, 0, 0);
        chk(davn, 1'b0, "R3 window ignored in line mode");
        pulse(1, 0, 0, 0, 0, 0);
        chk(davn, 1'b1, "R3 line16 releases");
    endtask

    task automatic t_window_modes();
        for (int m = 1; m < 4; m++) begin
            mode = 2'(m);
            pulse(0, 0, 0, 0, 1, 0);
            chk(davn, 1'b0, $sformatf("R2 store mode %0d", m));
            pulse(1, 0, 0, 0, 0, 0);
            chk(davn, 1'b0, $sformatf("R4 line16 ignored mode %0d", m));
            pulse(0, 1, 0, 0, 0, 0);
            chk(davn, 1'b1, $sformatf("R4 window releases mode %0d", m));
        end
    endtask

    task automatic t_nack();
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m);
            pulse(0, 0, 0, 0, 1, 0);
            pulse(0, 0, 0, 0, 0, 1);
            chk(davn, 1'b1, $sformatf("R5 nack releases mode %0d", m));
        end
    endtask

    task automatic t_priority();
        mode = 0;
        pulse(1, 0, 0, 0, 1, 0);
        chk(davn, 1'b0, "R6 store beats line16");
        mode = 1;
        pulse(0, 1, 0, 0, 1, 0);
        chk(davn, 1'b0, "R6 store beats window");
        pulse(0, 0, 0, 0, 1, 1);
        chk(davn, 1'b0, "R6 store beats nack");
        pulse(0, 0, 0, 0, 0, 1);
        chk(davn, 1'b1, "R5 nack after priority case");
    endtask

    task automatic t_field();
        pulse(0, 0, 1, 0, 0, 0);
        chk(ehb, 1'b1, "R7 first field sets");
        pulse(0, 0, 0, 0, 0, 0);
        chk(ehb, 1'b1, "R7 holds high");
        pulse(0, 0, 0, 1, 0, 0);
        chk(ehb, 1'b0, "R7 second field clears");
        pulse(0, 0, 0, 0, 0, 0);
        chk(ehb, 1'b0, "R7 holds low");
    endtask

    task automatic t_test();
        mode = 0;
        tst = 1; strap = 0;
        @(negedge clk);
        chk(davn, 1'b0, "R8 davn copies strap 0");
        chk(ehb,  1'b0, "R8 ehb copies strap 0");
        strap = 1;
        @(negedge clk);
        chk(davn, 1'b1, "R8 davn copies strap 1");
        chk(ehb,  1'b1, "R8 ehb copies strap 1");
        pulse(0, 0, 1, 0, 1, 0);
        chk(davn, 1'b1, "R8 strap holds davn despite store");
        strap = 0;
        @(negedge clk);
        chk(ehb, 1'b0, "R8 strap holds ehb despite field set");
        tst = 0;
        @(negedge clk);
        chk(davn, 1'b0, "R9 store tracked during test");
        chk(ehb,  1'b1, "R9 field tracked during test");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_line_mode();
        t_window_modes();
        t_nack();
        t_priority();
        t_field();
        t_test();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule